// File: doc/BRIEF.md
# Interrupt Presenter Context Matcher

This block sits next to one hardware thread's interrupt context and decides whether an incoming notification is meant for that thread. When it is, the block also reports which privilege ring is the target. Each notification carries five fields: a format bit, an ignore flag, a block id, a 24-bit virtual processor index and a logical server number. The block compares the notification against four context words, one each for the physical, hypervisor pool, OS and user rings. It also uses the thread's processor id register and the local block id.

The notification's target is a 28-bit CAM value. Its upper 4 bits are the block id and its lower 24 bits are the index. For the physical ring, the block builds the compared value from the local block id and a truncated processor id. The pool and OS rings compare against CAM fields held in their own context words. For the user ring, the OS ring identity and a logical server number must both agree.

The verdict is registered and appears in the cycle after the request strobe. It lasts for that one cycle only.

Top module: `irq_ctx_matcher`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `matchValid`, `matchRing` and `unsupported` are all 0.
- R2: The notification CAM is `{reqBlock, reqVpIndex}`, 28 bits wide. A pool or OS context word matches when its valid bit (logical bit 31) is 1 and its logical bits 27:0 equal the notification CAM.
- R3: When `tidWide` is 0, the physical ring compares against `{localBlock, 16'b0, 1'b1, procId[6:0]}`. Processor id bits above bit 6 have no effect.
- R4: When `tidWide` is 1, the physical ring compares against `{localBlock, 15'b0, 1'b1, procId[7:0]}`.
- R5: With format 0 and ignore 0, the rings are tried in the order physical, pool, OS, and the first hit wins. The ring codes are physical 3, pool 2, OS 1 and user 0.
- R6: A ring whose logical valid bit 31 is 0 never matches, even when its CAM field equals the notification CAM.
- R7: Each context port carries the stored bytes in big-endian order: port bits 7:0 hold logical bits 31:24, and port bits 31:24 hold logical bits 7:0. The byte swap happens before any field is used.
- R8: A format-0 request with the ignore flag set gives `unsupported`=1, `matchValid`=0 and `matchRing`=0, whatever the context words hold.
- R9: A format-1 request can only yield the user ring (code 0). This needs four conditions: the OS valid bit is set, the OS CAM equals the notification CAM, the user valid bit (logical bit 31) is set, and the user word's logical bits 23:0 equal `reqLogicServer`. The ignore flag has no effect, and physical or pool hits are not reported.
- R10: A request that hits no ring gives `matchValid`=0, `matchRing`=0 and `unsupported`=0.
- R11: The result appears in the cycle after the request strobe and lasts one cycle. In a cycle with no strobe, all outputs return to 0. Strobes on consecutive cycles each get their own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqFormat | input | 1 | 0: specific target, 1: user-level event branch |
| reqIgnore | input | 1 | Low-order-ignore request flag |
| reqBlock | input | 4 | Target block id |
| reqVpIndex | input | 24 | Target virtual processor index |
| reqLogicServer | input | 24 | Requested logical server number |
| ctxPhys | input | 32 | Physical ring context word, big-endian bytes |
| ctxPool | input | 32 | Pool ring context word, big-endian bytes |
| ctxOs | input | 32 | OS ring context word, big-endian bytes |
| ctxUser | input | 32 | User ring context word, big-endian bytes |
| procId | input | 32 | Thread processor id |
| localBlock | input | 4 | Local block id |
| tidWide | input | 1 | Thread id width select: 0 gives 7 bits, 1 gives 8 bits |
| matchValid | output | 1 | A ring matched |
| matchRing | output | 2 | Code of the matching ring |
| unsupported | output | 1 | Request uses the unsupported ignore mode |

## Verification
The block holds no state beyond its result register, so a bad internal decision shows up at the ports in the very next cycle. That decision could be a wrong hit vector, a skipped byte swap or a wrong priority. It appears as a wrong ring code, a missing or spurious `matchValid`, or a stray `unsupported`, and it does not carry over to later requests. The bench applies stimulus that splits the cases apart: several rings hit at once, a CAM matches but the valid bit is clear, the processor id has high bits set, and a word is swapped against one that is not. Each such stimulus yields a different verdict.

// File: rtl/irq_ctx_pkg.sv
package irq_ctx_pkg;
  localparam int BLK_W      = 4;
  localparam int IDX_W      = 24;
  localparam int CAM_W      = BLK_W + IDX_W;
  localparam int WORD_W     = 32;
  localparam int LS_W       = 24;
  localparam int PID_W      = 32;
  localparam int TID_NARROW = 7;

  typedef enum logic [1:0] {
    RING_USER = 2'd0,
    RING_OS   = 2'd1,
    RING_POOL = 2'd2,
    RING_PHYS = 2'd3
  } ring_e;

  typedef struct packed {
    logic physHit;
    logic poolHit;
    logic osHit;
    logic userHit;
  } hits_t;

  typedef struct packed {
    logic  load;
    logic  matchValid;
    ring_e ring;
    logic  unsupported;
  } ctrl_t;
endpackage

// File: rtl/irq_ctx_byteswap.sv
module irq_ctx_byteswap #(
  parameter int BYTES = 4,
  localparam int W = BYTES * 8
) (
  input  logic [W-1:0] stored,
  output logic [W-1:0] logical
);
  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign logical[(BYTES-1-b)*8 +: 8] = stored[b*8 +: 8];
  end
endmodule

// File: rtl/irq_ctx_datapath.sv
module irq_ctx_datapath
  import irq_ctx_pkg::*;
#(
  parameter int BLKW   = BLK_W,
  parameter int IDXW   = IDX_W,
  parameter int WORDW  = WORD_W,
  parameter int LSW    = LS_W,
  parameter int PIDW   = PID_W,
  parameter int TIDN   = TID_NARROW,
  localparam int CAMW  = BLKW + IDXW,
  localparam int TIDW  = TIDN + 1,
  localparam int NRING = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [BLKW-1:0]  reqBlock,
  input  logic [IDXW-1:0]  reqVpIndex,
  input  logic [LSW-1:0]   reqLogicServer,
  input  logic [WORDW-1:0] ctxPhys,
  input  logic [WORDW-1:0] ctxPool,
  input  logic [WORDW-1:0] ctxOs,
  input  logic [WORDW-1:0] ctxUser,
  input  logic [PIDW-1:0]  procId,
  input  logic [BLKW-1:0]  localBlock,
  input  logic             tidWide,
  input  ctrl_t            ctrl,
  output hits_t            hits,
  output logic             matchValid,
  output logic [1:0]       matchRing,
  output logic             unsupported
);
  localparam int VALID_BIT = WORDW - 1;

  logic [NRING-1:0][WORDW-1:0] storedWords;
  logic [NRING-1:0][WORDW-1:0] logicalWords;

  assign storedWords[3] = ctxPhys;
  assign storedWords[2] = ctxPool;
  assign storedWords[1] = ctxOs;
  assign storedWords[0] = ctxUser;

  for (genvar r = 0; r < NRING; r++) begin : g_swap
    irq_ctx_byteswap #(.BYTES(WORDW / 8)) swap_i (
      .stored (storedWords[r]),
      .logical(logicalWords[r])
    );
  end

  logic [CAMW-1:0] reqCam;
  assign reqCam = {reqBlock, reqVpIndex};

  logic [IDXW-1:0] physIdxNarrow;
  logic [IDXW-1:0] physIdxWide;
  logic [CAMW-1:0] physCam;

  assign physIdxNarrow = (IDXW'(1) << TIDN) | IDXW'(procId[TIDN-1:0]);
  assign physIdxWide   = (IDXW'(1) << TIDW) | IDXW'(procId[TIDW-1:0]);
  assign physCam       = {localBlock, (tidWide ? physIdxWide : physIdxNarrow)};

  logic [NRING-1:0] ringValid;
  for (genvar r = 0; r < NRING; r++) begin : g_valid
    assign ringValid[r] = logicalWords[r][VALID_BIT];
  end

  logic [CAMW-1:0] poolCam;
  logic [CAMW-1:0] osCam;
  logic [LSW-1:0]  userServer;

  assign poolCam    = logicalWords[2][CAMW-1:0];
  assign osCam      = logicalWords[1][CAMW-1:0];
  assign userServer = logicalWords[0][LSW-1:0];

  logic osIdentityOk;
  assign osIdentityOk = ringValid[1] && (osCam == reqCam);

  assign hits.physHit = ringValid[3] && (physCam == reqCam);
  assign hits.poolHit = ringValid[2] && (poolCam == reqCam);
  assign hits.osHit   = osIdentityOk;
  assign hits.userHit = osIdentityOk && ringValid[0] && (userServer == reqLogicServer);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      matchValid  <= 1'b0;
      matchRing   <= 2'd0;
      unsupported <= 1'b0;
    end else if (ctrl.load) begin
      matchValid  <= ctrl.matchValid;
      matchRing   <= ctrl.ring;
      unsupported <= ctrl.unsupported;
    end else begin
      matchValid  <= 1'b0;
      matchRing   <= 2'd0;
      unsupported <= 1'b0;
    end
  end

  logic unusedBits;
  assign unusedBits = ^{procId[PIDW-1:TIDW],
                        logicalWords[3][VALID_BIT-1:0],
                        logicalWords[2][VALID_BIT-1:CAMW],
                        logicalWords[1][VALID_BIT-1:CAMW],
                        logicalWords[0][VALID_BIT-1:LSW]};
endmodule

// File: rtl/irq_ctx_control.sv
module irq_ctx_control
  import irq_ctx_pkg::*;
(
  input  logic  reqValid,
  input  logic  reqFormat,
  input  logic  reqIgnore,
  input  hits_t hits,
  output ctrl_t ctrl
);
  always_comb begin
    ctrl             = '0;
    ctrl.load        = reqValid;
    ctrl.ring        = RING_USER;
    if (!reqFormat) begin
      if (reqIgnore) begin
        ctrl.unsupported = 1'b1;
      end else if (hits.physHit) begin
        ctrl.matchValid = 1'b1;
        ctrl.ring       = RING_PHYS;
      end else if (hits.poolHit) begin
        ctrl.matchValid = 1'b1;
        ctrl.ring       = RING_POOL;
      end else if (hits.osHit) begin
        ctrl.matchValid = 1'b1;
        ctrl.ring       = RING_OS;
      end
    end else if (hits.userHit) begin
      ctrl.matchValid = 1'b1;
      ctrl.ring       = RING_USER;
    end
  end
endmodule

// File: rtl/irq_ctx_matcher.sv
module irq_ctx_matcher
  import irq_ctx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqFormat,
  input  logic                 reqIgnore,
  input  logic [BLK_W-1:0]     reqBlock,
  input  logic [IDX_W-1:0]     reqVpIndex,
  input  logic [LS_W-1:0]      reqLogicServer,
  input  logic [WORD_W-1:0]    ctxPhys,
  input  logic [WORD_W-1:0]    ctxPool,
  input  logic [WORD_W-1:0]    ctxOs,
  input  logic [WORD_W-1:0]    ctxUser,
  input  logic [PID_W-1:0]     procId,
  input  logic [BLK_W-1:0]     localBlock,
  input  logic                 tidWide,
  output logic                 matchValid,
  output logic [1:0]           matchRing,
  output logic                 unsupported
);
  hits_t hits;
  ctrl_t ctrl;

  irq_ctx_control ctl_i (
    .reqValid (reqValid),
    .reqFormat(reqFormat),
    .reqIgnore(reqIgnore),
    .hits     (hits),
    .ctrl     (ctrl)
  );

  irq_ctx_datapath dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .reqBlock      (reqBlock),
    .reqVpIndex    (reqVpIndex),
    .reqLogicServer(reqLogicServer),
    .ctxPhys       (ctxPhys),
    .ctxPool       (ctxPool),
    .ctxOs         (ctxOs),
    .ctxUser       (ctxUser),
    .procId        (procId),
    .localBlock    (localBlock),
    .tidWide       (tidWide),
    .ctrl          (ctrl),
    .hits          (hits),
    .matchValid    (matchValid),
    .matchRing     (matchRing),
    .unsupported   (unsupported)
  );
endmodule

// File: rtl/irq_ctx_checker.sv
module irq_ctx_checker (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqFormat,
  input logic        reqIgnore,
  input logic [31:0] ctxPhys,
  input logic [31:0] ctxPool,
  input logic [31:0] ctxOs,
  input logic        matchValid,
  input logic [1:0]  matchRing,
  input logic        unsupported
);
  // R11: no strobe, quiet outputs next cycle
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!matchValid && !unsupported && matchRing == 2'd0));

  // R8: ignore mode on format 0 flags unsupported
  a_r8_unsupported: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqFormat && reqIgnore) |=> (unsupported && !matchValid && matchRing == 2'd0));

  // R9: format 1 never reports a non-user ring or unsupported
  a_r9_user_only: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqFormat) |=> (!unsupported && matchRing == 2'd0));

  // R10: ring code is zero whenever there is no match
  a_r10_ring_zero: assert property (@(posedge clk) disable iff (!rstN)
    !matchValid |-> matchRing == 2'd0);

  // R10: match and unsupported are exclusive
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(matchValid && unsupported));

  // R6, R7: logical valid bits sit at port bit 7; all clear means no match
  a_r6_valid_needed: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqFormat && !reqIgnore && !ctxPhys[7] && !ctxPool[7] && !ctxOs[7])
      |=> !matchValid);

  // R1: outputs clear in the cycle after reset
  a_r1_reset_clear: assert property (@(posedge clk)
    !rstN |=> (!matchValid && !unsupported && matchRing == 2'd0));
endmodule

bind irq_ctx_matcher irq_ctx_checker chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqFormat  (reqFormat),
  .reqIgnore  (reqIgnore),
  .ctxPhys    (ctxPhys),
  .ctxPool    (ctxPool),
  .ctxOs      (ctxOs),
  .matchValid (matchValid),
  .matchRing  (matchRing),
  .unsupported(unsupported)
);

// File: tb/irq_ctx_matcher_tb_top.sv
module irq_ctx_matcher_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqFormat = 1'b0;
  logic        reqIgnore = 1'b0;
  logic [3:0]  reqBlock = '0;
  logic [23:0] reqVpIndex = '0;
  logic [23:0] reqLogicServer = '0;
  logic [31:0] ctxPhys = '0;
  logic [31:0] ctxPool = '0;
  logic [31:0] ctxOs = '0;
  logic [31:0] ctxUser = '0;
  logic [31:0] procId = '0;
  logic [3:0]  localBlock = '0;
  logic        tidWide = 1'b0;
  logic        matchValid;
  logic [1:0]  matchRing;
  logic        unsupported;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  typedef struct {
    logic       mv;
    logic [1:0] ring;
    logic       uns;
    string      tag;
  } exp_t;

  exp_t sbq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_ctx_matcher dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqFormat(reqFormat),
    .reqIgnore(reqIgnore), .reqBlock(reqBlock), .reqVpIndex(reqVpIndex),
    .reqLogicServer(reqLogicServer), .ctxPhys(ctxPhys), .ctxPool(ctxPool),
    .ctxOs(ctxOs), .ctxUser(ctxUser), .procId(procId), .localBlock(localBlock),
    .tidWide(tidWide), .matchValid(matchValid), .matchRing(matchRing),
    .unsupported(unsupported)
  );

  function automatic logic [31:0] toStored(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic [31:0] camWord(input logic v, input logic [27:0] cam);
    return {v, 3'b000, cam};
  endfunction

  // Reference verdict built from the requirements (logical words in)
  function automatic exp_t model(input logic fmt, input logic ign,
                                 input logic [3:0] blk, input logic [23:0] idx,
                                 input logic [23:0] ls,
                                 input logic [31:0] ph, input logic [31:0] po,
                                 input logic [31:0] os, input logic [31:0] us,
                                 input logic [31:0] pid, input logic [3:0] lb,
                                 input logic wide, input string tag);
    exp_t e;
    logic [27:0] cam;
    logic [23:0] pidx;
    e.mv = 0; e.ring = 0; e.uns = 0; e.tag = tag;
    cam = {blk, idx};
    pidx = wide ? (24'h000100 | {16'h0, pid[7:0]}) : (24'h000080 | {17'h0, pid[6:0]});
    if (!fmt) begin
      if (ign) e.uns = 1;
      else if (ph[31] && {lb, pidx} == cam) begin e.mv = 1; e.ring = 3; end
      else if (po[31] && po[27:0] == cam)   begin e.mv = 1; e.ring = 2; end
      else if (os[31] && os[27:0] == cam)   begin e.mv = 1; e.ring = 1; end
    end else if (os[31] && os[27:0] == cam && us[31] && us[23:0] == ls) begin
      e.mv = 1; e.ring = 0;
    end
    return e;
  endfunction

  task automatic send(input logic fmt, input logic ign,
                      input logic [3:0] blk, input logic [23:0] idx,
                      input logic [23:0] ls,
                      input logic [31:0] ph, input logic [31:0] po,
                      input logic [31:0] os, input logic [31:0] us,
                      input logic [31:0] pid, input logic [3:0] lb,
                      input logic wide, input string tag);
    @(negedge clk);
    reqValid = 1; reqFormat = fmt; reqIgnore = ign; reqBlock = blk;
    reqVpIndex = idx; reqLogicServer = ls;
    ctxPhys = toStored(ph); ctxPool = toStored(po);
    ctxOs = toStored(os); ctxUser = toStored(us);
    procId = pid; localBlock = lb; tidWide = wide;
    sbq.push_back(model(fmt, ign, blk, idx, ls, ph, po, os, us, pid, lb, wide, tag));
  endtask

  task automatic sendRaw(input logic [31:0] ph, input logic [31:0] po,
                         input logic [31:0] os, input logic [3:0] blk,
                         input logic [23:0] idx, input exp_t e);
    @(negedge clk);
    reqValid = 1; reqFormat = 0; reqIgnore = 0; reqBlock = blk; reqVpIndex = idx;
    ctxPhys = ph; ctxPool = po; ctxOs = os; ctxUser = '0;
    sbq.push_back(e);
  endtask

  task automatic idle(input string tag);
    exp_t e;
    @(negedge clk);
    reqValid = 0; reqFormat = 1; reqIgnore = 1;
    e.mv = 0; e.ring = 0; e.uns = 0; e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic checkNow(input logic mv, input logic [1:0] ring, input logic uns,
                          input string tag);
    checks++;
    if (matchValid !== mv || matchRing !== ring || unsupported !== uns) begin
      errors++;
      $display("FAIL %s: got mv=%0d ring=%0d uns=%0d expected mv=%0d ring=%0d uns=%0d",
               tag, matchValid, matchRing, unsupported, mv, ring, uns);
    end
  endtask

  // Monitor: compares each scoreboard item after the edge that produced it
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rstN && sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        checkNow(e.mv, e.ring, e.uns, e.tag);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: got cycles=%0d expected under %0d", cycles, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] none;
    exp_t e;
    none = 32'h0;
    repeat (3) @(negedge clk);
    checkNow(0, 0, 0, "R1 during reset");
    @(negedge clk);
    rstN = 1;
    @(posedge clk); #1;
    checkNow(0, 0, 0, "R1 after reset");

    // R2: OS ring match on stored CAM
    send(0, 0, 4'h3, 24'h123456, 0, none, none, camWord(1, 28'h3123456), none,
         32'h0, 4'h0, 0, "R2 os match");
    // R2: pool match
    send(0, 0, 4'h5, 24'h00ABCD, 0, none, camWord(1, 28'h500ABCD), none, none,
         32'h0, 4'h0, 0, "R2 pool match");
    // R3: physical line, high pid bits ignored
    send(0, 0, 4'h2, 24'h0000A5, 0, camWord(1, 28'h0), none, none, none,
         32'hFFFF_FF25, 4'h2, 0, "R3 phys narrow");
    // R3: narrow CAM with index lacking the marker -> no match
    send(0, 0, 4'h2, 24'h000025, 0, camWord(1, 28'h0), none, none, none,
         32'h0000_0025, 4'h2, 0, "R3 marker required");
    // R4: wide thread id
    send(0, 0, 4'h7, 24'h0001C5, 0, camWord(1, 28'h0), none, none, none,
         32'h0000_00C5, 4'h7, 1, "R4 phys wide");
    // R4: narrow-form index misses in wide mode
    send(0, 0, 4'h7, 24'h0000C5, 0, camWord(1, 28'h0), none, none, none,
         32'h0000_00C5, 4'h7, 1, "R4 narrow form misses");
    // R5: all three rings hit, physical wins
    send(0, 0, 4'h1, 24'h000091, 0, camWord(1, 28'h0),
         camWord(1, 28'h1000091), camWord(1, 28'h1000091), none,
         32'h11, 4'h1, 0, "R5 phys over pool and os");
    // R5: pool over OS
    send(0, 0, 4'h9, 24'h777777, 0, none,
         camWord(1, 28'h9777777), camWord(1, 28'h9777777), none,
         32'h0, 4'h0, 0, "R5 pool over os");
    // R6: valid bits clear on pool, OS falls through
    send(0, 0, 4'h9, 24'h777777, 0, camWord(0, 28'h0),
         camWord(0, 28'h9777777), camWord(1, 28'h9777777), none,
         32'h0, 4'h0, 0, "R6 pool invalid falls to os");
    // R6: nothing valid
    send(0, 0, 4'h9, 24'h777777, 0, none,
         camWord(0, 28'h9777777), camWord(0, 28'h9777777), none,
         32'h0, 4'h0, 0, "R6 all invalid");
    // R7: unswapped word on the port does not match
    e.mv = 0; e.ring = 0; e.uns = 0; e.tag = "R7 unswapped word misses";
    sendRaw(32'h0, 32'h0, camWord(1, 28'h4010203), 4'h4, 24'h010203, e);
    // R7: correctly swapped word matches OS
    e.mv = 1; e.ring = 1; e.uns = 0; e.tag = "R7 swapped word matches";
    sendRaw(32'h0, 32'h0, 32'h0302_0184, 4'h4, 24'h010203, e);
    // R8: ignore mode with a matching OS word
    send(0, 1, 4'h3, 24'h123456, 0, none, none, camWord(1, 28'h3123456), none,
         32'h0, 4'h0, 0, "R8 ignore unsupported");
    // R9: user ring match, ignore flag set has no effect
    send(1, 1, 4'hA, 24'h0F0F0F, 24'h00BEEF, none, none, camWord(1, 28'hA0F0F0F),
         {1'b1, 7'h0, 24'h00BEEF}, 32'h0, 4'h0, 0, "R9 user match");
    // R9: logical server mismatch
    send(1, 0, 4'hA, 24'h0F0F0F, 24'h00BEEE, none, none, camWord(1, 28'hA0F0F0F),
         {1'b1, 7'h0, 24'h00BEEF}, 32'h0, 4'h0, 0, "R9 server mismatch");
    // R9: user invalid
    send(1, 0, 4'hA, 24'h0F0F0F, 24'h00BEEF, none, none, camWord(1, 28'hA0F0F0F),
         {1'b0, 7'h0, 24'h00BEEF}, 32'h0, 4'h0, 0, "R9 user invalid");
    // R9: OS invalid
    send(1, 0, 4'hA, 24'h0F0F0F, 24'h00BEEF, none, none, camWord(0, 28'hA0F0F0F),
         {1'b1, 7'h0, 24'h00BEEF}, 32'h0, 4'h0, 0, "R9 os invalid");
    // R9: physical would hit but format 1 reports nothing
    send(1, 0, 4'h2, 24'h0000A5, 0, camWord(1, 28'h0), camWord(1, 28'h20000A5), none,
         none, 32'h25, 4'h2, 0, "R9 phys ignored in format 1");
    // R10: no ring matches
    send(0, 0, 4'h6, 24'h333333, 0, camWord(1, 28'h0), camWord(1, 28'h6333334),
         camWord(1, 28'h5333333), none, 32'h0, 4'h6, 0, "R10 no match");
    // R11: back-to-back then idle
    send(0, 0, 4'h3, 24'h123456, 0, none, none, camWord(1, 28'h3123456), none,
         32'h0, 4'h0, 0, "R11 back to back 1");
    send(0, 0, 4'h5, 24'h00ABCD, 0, none, camWord(1, 28'h500ABCD), none, none,
         32'h0, 4'h0, 0, "R11 back to back 2");
    idle("R11 idle clears");
    idle("R11 idle stays clear");

    repeat (4) @(negedge clk);
    if (sbq.size() != 0) begin
      errors++;
      checks++;
      $display("FAIL scoreboard: got %0d pending expected 0", sbq.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule